// File: doc/BRIEF.md
# Infrared remote frame transmitter

This block builds one pulse-distance infrared remote-control frame on a single output that drives an emitter LED stage. It runs from a 50 MHz clock. All frame timing is counted in one base unit of 562.5 µs, which is `UNIT_CYC` clock cycles. A frame carries an 8-bit address and an 8-bit command. It starts with a long leader, then sends 32 data bits and ends with a short closing burst. A new frame starts every 192 units (108 ms).

While `sendEn` is high, frames follow one another with no pause beyond the fixed frame period. When `sendEn` goes low, the frame in progress still runs to its end, and then the block goes idle. The output is the baseband envelope, where high means burst. When `USE_CARRIER` is set, every burst is instead chopped into a carrier square wave with roughly one-third duty, for example 38 kHz at 50 MHz.

Top module: `ir_frame_tx`

## Requirements
- R1: After reset, `irOut` and `busy` are low and stay low while `sendEn` is low.
- R2: A frame opens with 16 units of burst followed by 8 units of space.
- R3: A data bit of value 0 is sent as 1 unit of burst followed by 1 unit of space.
- R4: A data bit of value 1 is sent as 1 unit of burst followed by 3 units of space.
- R5: The 32 data bits are sent LSB first, in this order: the address, its bitwise inverse, the command, its bitwise inverse.
- R6: One unit of burst follows the last data bit. `busy` is high from the first leader cycle to the last cycle of that closing burst and low otherwise.
- R7: Frames start exactly 192 units apart. The output is low between the closing burst and the next frame. Frames repeat back to back while `sendEn` is held high.
- R8: When `sendEn` is low at the end of a frame, the block returns to idle with `irOut` and `busy` low.
- R9: The address and command are captured in the cycle a frame starts. Changes made to them later in that frame do not alter it.
- R10: With `USE_CARRIER`=1, during a burst `irOut` is high for the first `CARR_HIGH` cycles of every `CARR_PERIOD` cycles, counted from the start of that burst. During a space it is low.
- R11: From idle, a high `sendEn` sampled at a clock edge starts the leader in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| sendEn | input | 1 | Hold high to keep transmitting frames |
| addrIn | input | 8 | Device address to transmit |
| cmdIn | input | 8 | Command code to transmit |
| irOut | output | 1 | Envelope or carrier-gated drive for the emitter |
| busy | output | 1 | High from leader start to end of closing burst |

## Verification
The bench builds two copies of the block with `UNIT_CYC`=4 instead of 28125. This shrinks a full 192-unit frame to 768 cycles, so back-to-back frames, release after a frame, and mid-frame input changes all fit in a short run. Because every cycle is checked against a frame model, an error of a single cycle in any unit count shows up. The second copy sets `USE_CARRIER`=1 with `CARR_PERIOD`=3 and `CARR_HIGH`=1. This makes the carrier restart at each burst edge visible cycle by cycle, both in the long leader and in the one-unit bursts.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int FRAME_BITS = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD_MARK, ST_LEAD_SPACE, ST_BIT_MARK, ST_BIT_SPACE, ST_STOP, ST_GAP
  } txState_t;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
  } txStrobe_t;
endpackage

// File: rtl/ir_tx_ctrl.sv
module ir_tx_ctrl
  import ir_tx_pkg::*;
#(
  parameter int UNIT_CYC         = 28125,
  parameter int FRAME_UNITS      = 192,
  parameter int LEAD_MARK_UNITS  = 16,
  parameter int LEAD_SPACE_UNITS = 8,
  parameter int ONE_SPACE_UNITS  = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sendEn,
  input  logic      curBit,
  output txStrobe_t strb,
  output logic      markOn,
  output logic      busy
);
  localparam int UW = $clog2(UNIT_CYC + 1);
  localparam int FW = $clog2(FRAME_UNITS + 1);
  localparam int BW = $clog2(FRAME_BITS);

  txState_t       state;
  logic [UW-1:0]  unitCnt;
  logic [FW-1:0]  phCnt;
  logic [FW-1:0]  frameUnits;
  logic [BW-1:0]  bitCnt;
  logic [FW-1:0]  phaseLen;
  logic           unitTick, phaseEnd, gapEnd;

  assign unitTick = (unitCnt == UW'(UNIT_CYC - 1));

  always_comb begin
    case (state)
      ST_LEAD_MARK:  phaseLen = FW'(LEAD_MARK_UNITS);
      ST_LEAD_SPACE: phaseLen = FW'(LEAD_SPACE_UNITS);
      ST_BIT_SPACE:  phaseLen = curBit ? FW'(ONE_SPACE_UNITS) : FW'(1);
      default:       phaseLen = FW'(1);
    endcase
  end

  assign phaseEnd = unitTick && (phCnt == phaseLen - FW'(1)) &&
                    (state != ST_IDLE) && (state != ST_GAP);
  assign gapEnd   = unitTick && (state == ST_GAP) &&
                    (frameUnits == FW'(FRAME_UNITS - 1));

  assign strb.loadFrame = sendEn && ((state == ST_IDLE) || gapEnd);
  assign strb.shiftBit  = phaseEnd && (state == ST_BIT_SPACE);
  assign markOn = (state == ST_LEAD_MARK) || (state == ST_BIT_MARK) || (state == ST_STOP);
  assign busy   = (state != ST_IDLE) && (state != ST_GAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      unitCnt    <= '0;
      phCnt      <= '0;
      frameUnits <= '0;
      bitCnt     <= '0;
    end else if (strb.loadFrame) begin
      state      <= ST_LEAD_MARK;
      unitCnt    <= '0;
      phCnt      <= '0;
      frameUnits <= '0;
      bitCnt     <= '0;
    end else if (state != ST_IDLE) begin
      unitCnt <= unitTick ? '0 : unitCnt + UW'(1);
      if (unitTick) begin
        frameUnits <= frameUnits + FW'(1);
        if (state != ST_GAP) phCnt <= phaseEnd ? '0 : phCnt + FW'(1);
      end
      if (phaseEnd) begin
        case (state)
          ST_LEAD_MARK:  state <= ST_LEAD_SPACE;
          ST_LEAD_SPACE: state <= ST_BIT_MARK;
          ST_BIT_MARK:   state <= ST_BIT_SPACE;
          ST_BIT_SPACE: begin
            bitCnt <= bitCnt + BW'(1);
            state  <= (bitCnt == BW'(FRAME_BITS - 1)) ? ST_STOP : ST_BIT_MARK;
          end
          ST_STOP:       state <= ST_GAP;
          default:       state <= state;
        endcase
      end
      if (gapEnd) state <= ST_IDLE;
    end
  end

  // R7: the frame unit counter never runs past one frame period while active
  p_frame_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (frameUnits < FW'(FRAME_UNITS)));

  // R11: busy only rises after a start request was seen
  p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sendEn));

  // R6: a frame always opens with a burst
  p_open_burst_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> markOn);
endmodule

// File: rtl/ir_tx_datapath.sv
module ir_tx_datapath
  import ir_tx_pkg::*;
#(
  parameter bit USE_CARRIER = 1'b0,
  parameter int CARR_PERIOD = 1316,
  parameter int CARR_HIGH   = 439
) (
  input  logic       clk,
  input  logic       rstN,
  input  txStrobe_t  strb,
  input  logic [7:0] addrIn,
  input  logic [7:0] cmdIn,
  input  logic       markOn,
  output logic       curBit,
  output logic       irOut
);
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strb.loadFrame) shiftReg <= {~cmdIn, cmdIn, ~addrIn, addrIn};
    else if (strb.shiftBit)  shiftReg <= shiftReg >> 1;
  end

  assign curBit = shiftReg[0];

  generate
    if (USE_CARRIER) begin : g_carrier
      localparam int CW = $clog2(CARR_PERIOD + 1);
      logic [CW-1:0] carrCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       carrCnt <= '0;
        else if (!markOn) carrCnt <= '0;
        else             carrCnt <= (carrCnt == CW'(CARR_PERIOD - 1)) ? '0 : carrCnt + CW'(1);
      end
      assign irOut = markOn && (carrCnt < CW'(CARR_HIGH));
    end else begin : g_plain
      assign irOut = markOn;
    end
  endgenerate

  // R9: captured frame data only moves on a load or a bit shift
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadFrame && !strb.shiftBit) |=> $stable(shiftReg));
endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
  import ir_tx_pkg::*;
#(
  parameter int UNIT_CYC    = 28125,
  parameter int FRAME_UNITS = 192,
  parameter bit USE_CARRIER = 1'b0,
  parameter int CARR_PERIOD = 1316,
  parameter int CARR_HIGH   = 439
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sendEn,
  input  logic [7:0] addrIn,
  input  logic [7:0] cmdIn,
  output logic       irOut,
  output logic       busy
);
  txStrobe_t strb;
  logic      markOn, curBit;

  ir_tx_ctrl #(.UNIT_CYC(UNIT_CYC), .FRAME_UNITS(FRAME_UNITS),
               .LEAD_MARK_UNITS(16), .LEAD_SPACE_UNITS(8), .ONE_SPACE_UNITS(3)) uCtrl (
    .clk(clk), .rstN(rstN), .sendEn(sendEn), .curBit(curBit),
    .strb(strb), .markOn(markOn), .busy(busy));

  ir_tx_datapath #(.USE_CARRIER(USE_CARRIER), .CARR_PERIOD(CARR_PERIOD),
                   .CARR_HIGH(CARR_HIGH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .cmdIn(cmdIn),
    .markOn(markOn), .curBit(curBit), .irOut(irOut));

  // R10: no light leaves the emitter during a space
  p_space_dark_r10: assert property (@(posedge clk) disable iff (!rstN)
    !markOn |-> !irOut);
endmodule

// File: tb/sim_ir_frame_tx.sv
module sim_ir_frame_tx;
  localparam int CLK_PERIOD = 20;
  localparam int U  = 4;
  localparam int FU = 192;
  localparam int FR = U * FU;
  localparam int CP = 3;
  localparam int CH = 1;

  logic clk = 1'b0, rstN = 1'b0, sendEn = 1'b0;
  logic [7:0] addrIn = 8'h00, cmdIn = 8'h00;
  logic irOut, busy, irCarr, busyCarr;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_frame_tx #(.UNIT_CYC(U), .FRAME_UNITS(FU), .USE_CARRIER(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .sendEn(sendEn), .addrIn(addrIn), .cmdIn(cmdIn),
    .irOut(irOut), .busy(busy));
  ir_frame_tx #(.UNIT_CYC(U), .FRAME_UNITS(FU), .USE_CARRIER(1'b1),
                .CARR_PERIOD(CP), .CARR_HIGH(CH)) u1 (
    .clk(clk), .rstN(rstN), .sendEn(sendEn), .addrIn(addrIn), .cmdIn(cmdIn),
    .irOut(irCarr), .busy(busyCarr));

  // {addr, cmd, hold sendEn, change inputs mid-frame}
  typedef struct packed { logic [7:0] a; logic [7:0] c; logic hold; logic chg; } vec_t;
  localparam vec_t VECS [5] = '{
    '{8'h00, 8'hFF, 1'b1, 1'b0},
    '{8'hA5, 8'h3C, 1'b0, 1'b0},
    '{8'h01, 8'h80, 1'b1, 1'b1},
    '{8'h7E, 8'h12, 1'b1, 1'b0},
    '{8'hC3, 8'h0F, 1'b0, 1'b1}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // returns {busy, mark} for frame unit u
  function automatic logic [1:0] expUnit(input logic [7:0] a, input logic [7:0] c, input int u);
    logic [31:0] d;
    int pos;
    d = {~c, c, ~a, a};
    if (u < 16) return 2'b11;          // R2 leader burst
    if (u < 24) return 2'b10;          // R2 leader space
    pos = 24;
    for (int i = 0; i < 32; i++) begin // R5 LSB first order
      if (u == pos) return 2'b11;
      pos++;
      if (u < pos + (d[i] ? 3 : 1)) return 2'b10; // R3 / R4
      pos += d[i] ? 3 : 1;
    end
    if (u == pos) return 2'b11;        // R6 closing burst
    return 2'b00;                      // R7 gap
  endfunction

  task automatic runFrame(input logic [7:0] a, input logic [7:0] c, input logic hold, input logic chg);
    logic [1:0] e;
    int u, off;
    sendEn = 1'b1; addrIn = a; cmdIn = c;
    for (int cyc = 0; cyc < FR; cyc++) begin
      @(negedge clk);
      if (cyc == 0 && !hold) sendEn = 1'b0;
      if (chg && cyc == 10 * U) begin addrIn = ~a; cmdIn = c ^ 8'h5A; end // R9
      u = cyc / U;
      e = expUnit(a, c, u);
      chk(irOut == e[0], "R2/R3/R4/R5/R7/R9/R11 envelope", irOut, e[0]);
      chk(busy == e[1], "R6 busy", busy, e[1]);
      off = (u < 16) ? cyc : cyc % U;
      chk(irCarr == (e[0] && (off % CP) < CH), "R10 carrier", irCarr,
          e[0] && (off % CP) < CH);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irOut == 1'b0 && irCarr == 1'b0, "R1 reset out", irOut, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(irOut == 1'b0 && busy == 1'b0, "R1 idle", irOut, 0);
    end
    foreach (VECS[k]) begin
      runFrame(VECS[k].a, VECS[k].c, VECS[k].hold, VECS[k].chg);
      if (!VECS[k].hold) begin
        for (int i = 0; i < 2 * U; i++) begin
          @(negedge clk);
          chk(irOut == 1'b0 && irCarr == 1'b0, "R8 idle out", irOut, 0);
          chk(busy == 1'b0, "R8 idle busy", busy, 0);
        end
      end
    end
    // R11: a single-cycle request from idle still yields a whole frame
    runFrame(8'hFF, 8'h00, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule